// File: doc/BRIEF.md
# Double-Buffered Up-Count PWM Generator

This block produces one pulse-width-modulated output from an up-counting time base. The period and compare values are double-buffered. Software writes shadow copies through a small write-only register port. The comparators only ever see the active copies. Shadows move into the active registers together, on a counter boundary picked by a control field: either the counter reaching zero or the counter reaching the period.

Two transfer policies exist. In continuous mode every selected boundary copies the shadows. In one-shot mode nothing is copied until software arms a load. The next boundary then copies period and compare in the same cycle and the arm flag drops by itself. Software can therefore write a full parameter set at leisure, arm, and watch a status output to see when the set took effect. A half-written set can never reach the comparators.

The output is driven by an action qualifier. It holds an independent choice of no action, set or clear for the zero, period and compare-up events. This gives 0 to 100 percent duty and lets the output be switched off and on again without a runt pulse.

Top module: `shpwm_top`

## Requirements
- R1: The counter runs 0, 1, ..., active period, then returns to 0 on the following cycle. `ctr_out` shows the counter value.
- R2: While no transfer happens, writes to the shadow period (address 1) or shadow compare (address 2) leave the active values, and so the output timing, unchanged.
- R3: Control register (address 0) bit 1 selects the policy: 0 means continuous, where every selected boundary copies both shadows. Bit 0 selects the boundary: 0 means counter equals zero, 1 means counter equals period. The copied values are in force from the next counter value on.
- R4: In one-shot mode, writing 1 to bit 0 at address 3 arms a load. `oneshot_pending` goes high on the next cycle. The next selected boundary copies both shadows together and clears `oneshot_pending`.
- R5: Control bits [3:2], [5:4] and [7:6] hold the actions for the zero, period and compare-up events, coded 00 no action, 01 clear, 10 set, 11 no action. When events coincide, clear beats set and set beats no action. The output changes one cycle after the counter value that raised the event.
- R6: With zero set to high and compare-up cleared to low, the output is high for exactly min(compare, period+1) cycles of every period. A compare of 0 gives a constant low output, and any compare above the period gives a constant high output.
- R7: With period set to high and compare-up cleared to low, the output is high for compare+1 cycles. Changing the period action to clear holds the output low. Restoring set brings back the same duty.
- R8: A shadow write that lands in the same cycle as a transfer does not take part in it: the old shadow value is copied, and the new value waits for the next transfer.
- R9: Reset gives counter 0, output low, `oneshot_pending` low, all control fields 0, and active and shadow values equal to the parameter defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 period, 2 compare, 3 arm |
| wr_data | input | CW | Write data; control uses bits [7:0] |
| pwm_out | output | 1 | PWM output |
| ctr_out | output | CW | Time-base counter value |
| oneshot_pending | output | 1 | One-shot load armed and not yet done |

## Verification
A software write and a shadow-to-active transfer can fall in the same cycle. The bench provokes this by watching `ctr_out` and placing a period write exactly on the cycle where the counter sits at the selected boundary, once for the zero boundary and once for the period boundary. It then measures the counter maximum over the following periods. The first period must keep the old length and the next one must use the new length, which shows the write was held back whole rather than mixed into the copy. Event coincidence is covered the same way: a compare value of 0 makes zero-set and compare-clear fire together, and the output must stay low.

// File: rtl/shpwm_pkg.sv
package shpwm_pkg;

    localparam int AW = 2;

    localparam logic [AW-1:0] ADDR_CTRL = 2'd0;
    localparam logic [AW-1:0] ADDR_PRD  = 2'd1;
    localparam logic [AW-1:0] ADDR_CMP  = 2'd2;
    localparam logic [AW-1:0] ADDR_ARM  = 2'd3;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_CLR  = 2'b01,
        ACT_SET  = 2'b10,
        ACT_HOLD = 2'b11
    } act_e;

    typedef enum logic {
        LD_AT_ZERO = 1'b0,
        LD_AT_PRD  = 1'b1
    } ldsel_e;

    typedef enum logic {
        GL_CONT    = 1'b0,
        GL_ONESHOT = 1'b1
    } glmode_e;

    // packed MSB first: [7:6] cmp, [5:4] prd, [3:2] zero, [1] mode, [0] sel
    typedef struct packed {
        act_e    cmp_act;
        act_e    prd_act;
        act_e    zro_act;
        glmode_e gl_mode;
        ldsel_e  ld_sel;
    } ctrl_t;

    typedef struct packed {
        logic zro;
        logic prd;
        logic cmp;
    } evt_t;

    function automatic logic hit_is(input act_e a, input logic hit, input act_e want);
        return hit && (a == want);
    endfunction

    function automatic logic next_level(input logic cur, input ctrl_t c, input evt_t e);
        logic clr;
        logic set;
        clr = hit_is(c.zro_act, e.zro, ACT_CLR) || hit_is(c.prd_act, e.prd, ACT_CLR)
           || hit_is(c.cmp_act, e.cmp, ACT_CLR);
        set = hit_is(c.zro_act, e.zro, ACT_SET) || hit_is(c.prd_act, e.prd, ACT_SET)
           || hit_is(c.cmp_act, e.cmp, ACT_SET);
        if (clr)      return 1'b0;
        else if (set) return 1'b1;
        else          return cur;
    endfunction

endpackage

// File: rtl/shpwm_regs.sv
module shpwm_regs
    import shpwm_pkg::*;
#(
    parameter int CW      = 16,
    parameter int RST_PRD = 9,
    parameter int RST_CMP = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  evt_t          evt,
    output ctrl_t         ctrl,
    output logic [CW-1:0] act_prd,
    output logic [CW-1:0] act_cmp,
    output logic          armed,
    output logic          xfer
);
    localparam logic [CW-1:0] PRD_INIT = CW'(RST_PRD);
    localparam logic [CW-1:0] CMP_INIT = CW'(RST_CMP);

    logic [CW-1:0] sh_prd;
    logic [CW-1:0] sh_cmp;
    logic          ld_evt;
    logic          arm_wr;

    assign ld_evt = (ctrl.ld_sel == LD_AT_PRD) ? evt.prd : evt.zro;
    assign arm_wr = wr_en && (wr_addr == ADDR_ARM) && wr_data[0];
    assign xfer   = ld_evt && ((ctrl.gl_mode == GL_CONT) || armed);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            sh_prd <= PRD_INIT;
            sh_cmp <= CMP_INIT;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL: ctrl   <= ctrl_t'(wr_data[7:0]);
                ADDR_PRD:  sh_prd <= wr_data;
                ADDR_CMP:  sh_cmp <= wr_data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_prd <= PRD_INIT;
            act_cmp <= CMP_INIT;
        end else if (xfer) begin
            act_prd <= sh_prd;
            act_cmp <= sh_cmp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         armed <= 1'b0;
        else if (arm_wr) armed <= 1'b1;
        else if (xfer)   armed <= 1'b0;
    end

    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (armed && ld_evt && !arm_wr) |=> !armed); // R4
    AST_ACT_STABLE: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> ($stable(act_prd) && $stable(act_cmp))); // R2
endmodule

// File: rtl/shpwm_timebase.sv
module shpwm_timebase
    import shpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] act_prd,
    input  logic [CW-1:0] act_cmp,
    output logic [CW-1:0] ctr,
    output evt_t          evt
);
    always_ff @(posedge clk) begin
        if (rst)                ctr <= '0;
        else if (ctr >= act_prd) ctr <= '0;
        else                    ctr <= ctr + 1'b1;
    end

    always_comb begin
        evt.zro = (ctr == '0);
        evt.prd = (ctr == act_prd);
        evt.cmp = (ctr == act_cmp);
    end

    AST_CTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (ctr == act_prd) |=> (ctr == '0)); // R1
endmodule

// File: rtl/shpwm_action.sv
module shpwm_action
    import shpwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  evt_t  evt,
    output logic  pwm
);
    logic any_clr;

    assign any_clr = hit_is(ctrl.zro_act, evt.zro, ACT_CLR)
                  || hit_is(ctrl.prd_act, evt.prd, ACT_CLR)
                  || hit_is(ctrl.cmp_act, evt.cmp, ACT_CLR);

    always_ff @(posedge clk) begin
        if (rst) pwm <= 1'b0;
        else     pwm <= next_level(pwm, ctrl, evt);
    end

    AST_CLEAR_PRIO: assert property (@(posedge clk) disable iff (rst)
        any_clr |=> !pwm); // R5
endmodule

// File: rtl/shpwm_top.sv
module shpwm_top
    import shpwm_pkg::*;
#(
    parameter int CW      = 16,
    parameter int RST_PRD = 9,
    parameter int RST_CMP = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic          pwm_out,
    output logic [CW-1:0] ctr_out,
    output logic          oneshot_pending
);
    ctrl_t         ctrl;
    evt_t          evt;
    logic [CW-1:0] act_prd;
    logic [CW-1:0] act_cmp;
    logic          xfer;

    shpwm_regs #(.CW(CW), .RST_PRD(RST_PRD), .RST_CMP(RST_CMP)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .evt(evt), .ctrl(ctrl), .act_prd(act_prd), .act_cmp(act_cmp),
        .armed(oneshot_pending), .xfer(xfer)
    );

    shpwm_timebase #(.CW(CW)) u_tb (
        .clk(clk), .rst(rst), .act_prd(act_prd), .act_cmp(act_cmp),
        .ctr(ctr_out), .evt(evt)
    );

    shpwm_action u_aq (
        .clk(clk), .rst(rst), .ctrl(ctrl), .evt(evt), .pwm(pwm_out)
    );

    AST_XFER_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
        xfer |-> ((ctrl.ld_sel == LD_AT_PRD) ? (ctr_out == act_prd) : (ctr_out == '0))); // R3
endmodule

// File: tb/test_shpwm_top.sv
module test_shpwm_top;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic          pwm_out;
    logic [CW-1:0] ctr_out;
    logic          oneshot_pending;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    shpwm_top #(.CW(CW), .RST_PRD(9), .RST_CMP(0)) i_shpwm_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_out(pwm_out), .ctr_out(ctr_out), .oneshot_pending(oneshot_pending)
    );

    // {period, compare, expected high cycles per period}, zero-set / compare-clear
    localparam int NV = 10;
    localparam int VEC [NV][3] = '{
        '{9, 0, 0}, '{9, 3, 3}, '{9, 9, 9}, '{9, 10, 10}, '{4, 2, 2},
        '{4, 5, 5}, '{15, 1, 1}, '{15, 16, 16}, '{7, 12, 8}, '{1, 1, 1}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_at(input logic [1:0] a, input int d, input int c);
        do @(negedge clk); while (int'(ctr_out) != c);
        wr(a, d);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int cnt);
        cnt = 0;
        repeat (n) begin
            @(negedge clk);
            cnt += int'(pwm_out);
        end
    endtask

    task automatic period_max(output int m);
        m = 0;
        forever begin
            @(negedge clk);
            if (ctr_out == '0) break;
            if (int'(ctr_out) > m) m = int'(ctr_out);
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int h;
        int m;
        repeat (3) @(negedge clk);
        check("R9 pwm", int'(pwm_out), 0);
        check("R9 ctr", int'(ctr_out), 0);
        check("R9 pending", int'(oneshot_pending), 0);
        rst = 1'b0;
        idle(25);
        check("R9 output low with cleared actions", int'(pwm_out), 0);

        // R1: counter wraps at default period 9
        period_max(m);
        period_max(m);
        check("R1 wrap", m, 9);

        // R6 / R5 / R3: vector table, continuous load at period event
        wr(2'd0, 'h49);
        for (int i = 0; i < NV; i++) begin
            wr(2'd1, VEC[i][0]);
            wr(2'd2, VEC[i][1]);
            idle(60);
            count_high(VEC[i][0] + 1, h);
            check($sformatf("R6 vec%0d duty", i), h, VEC[i][2]);
        end

        // R7: set on period, clear on compare, then disable and re-enable
        wr(2'd1, 9);
        wr(2'd2, 3);
        wr(2'd0, 'h61);
        idle(40);
        count_high(10, h);
        check("R7 enabled duty", h, 4);
        wr(2'd0, 'h51);
        idle(25);
        count_high(20, h);
        check("R7 disabled low", h, 0);
        wr(2'd0, 'h61);
        idle(25);
        count_high(10, h);
        check("R7 re-enabled duty", h, 4);

        // R2 / R4: one-shot at zero, zero-set compare-clear
        wr(2'd0, 'h4A);
        idle(20);
        wr(2'd1, 5);
        wr(2'd2, 2);
        idle(40);
        period_max(m);
        period_max(m);
        check("R2 period held while unarmed", m, 9);
        count_high(10, h);
        check("R2 duty held while unarmed", h, 3);
        check("R4 pending idle", int'(oneshot_pending), 0);
        wr(2'd3, 1);
        check("R4 pending after arm", int'(oneshot_pending), 1);
        idle(40);
        check("R4 pending self-clears", int'(oneshot_pending), 0);
        period_max(m);
        period_max(m);
        check("R4 new period", m, 5);
        count_high(6, h);
        check("R4 new duty", h, 2);

        // R8 / R3: write coinciding with zero-boundary transfer (continuous)
        wr(2'd0, 'h48);
        idle(20);
        wr_at(2'd1, 11, 0);
        period_max(m);
        check("R8 zero: old period kept", m, 5);
        period_max(m);
        check("R8 zero: new period next", m, 11);

        // R8 / R3: write coinciding with period-boundary transfer
        wr(2'd0, 'h49);
        wr_at(2'd1, 7, 11);
        period_max(m);
        check("R8 period: old period kept", m, 11);
        period_max(m);
        check("R8 period: new period next", m, 7);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule